// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a 40-bit physical address. It takes one request at a time over a valid/ready handshake and reads two 32-bit table words from memory to resolve it. The directory, or first level, is indexed by virtual bits 31:22. It names a leaf table, or second level, which is indexed by virtual bits 21:12. Pages are 4 KiB, so virtual bits 11:0 pass through unchanged.

A missing entry, or a write to a page without write permission, does not abort the access. The address is steered into a safe page instead. There is one safe page for secure requests and one for non-secure requests. The first such fault is latched with its virtual address and cause until it is cleared.

A one-entry register keeps the most recent page result, so a repeat access to the same page needs no table reads. Any change to the directory base or to the enable input drops that entry. While translation is off, the address is passed through zero-extended.

Top module: `xw_walker`

## Requirements
- R1: `req_ready` is high only while no request is in progress. Each accepted request yields exactly one single-cycle `rsp_valid` pulse. `mem_rd_req` is never high while `req_ready` is high.
- R2: When `cfg_enable` is 0 at acceptance, the response is `{8'h00, va}` with `rsp_fault`=0, and no table read is issued.
- R3: On a miss, the first read goes to address `{cfg_dir_page, va[31:22], 2'b00}`.
- R4: If the directory entry is usable, the second read goes to `{dir_entry[31:12], va[21:12], 2'b00}`.
- R5: In every table entry, bit 0 is present, bit 1 is exception and bit 2 is writable. An entry is usable only when it is present and its exception bit is clear. An unusable directory entry faults after a single read.
- R6: A usable leaf entry gives the physical address `{leaf[11:4], leaf[31:12], va[11:0]}`.
- R7: A write request (`req_write`=1) to a leaf whose writable bit is 0 faults.
- R8: On a fault, `rsp_fault`=1 and `rsp_pa` is `{hi, page, va[11:0]}`. A non-secure request uses `hi`=`cfg_safe_hi[7:0]` and `page`=`cfg_safe_ns_page`. A secure request (`req_secure`=1) uses `hi`=`cfg_safe_hi[15:8]` and `page`=`cfg_safe_sec_page`.
- R9: The first fault sets `flt_sticky` and stores the virtual address in `flt_va` and the cause in `flt_kind`. The cause codes are 1 for an unusable directory entry, 2 for an unusable leaf and 3 for a write denied. Later faults leave the stored values unchanged until a `flt_clr` pulse clears `flt_sticky`.
- R10: After a usable leaf is read, a request to the same virtual page issues no table reads. It returns the same page, and write permission is still checked.
- R11: Any change of `cfg_dir_page` or `cfg_enable` drops the remembered translation, so the next request walks the tables again.
- R12: After reset, `req_ready`=1, `rsp_valid`=0, `mem_rd_req`=0 and `flt_sticky`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Translation on |
| cfg_dir_page | input | 20 | Directory table base, bits 31:12 |
| cfg_safe_ns_page | input | 20 | Non-secure safe page, bits 31:12 |
| cfg_safe_sec_page | input | 20 | Secure safe page, bits 31:12 |
| cfg_safe_hi | input | 16 | Safe page bits 39:32: [7:0] non-secure, [15:8] secure |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write |
| req_secure | input | 1 | Request is secure |
| rsp_valid | output | 1 | Result pulse |
| rsp_pa | output | 40 | Physical or safe address |
| rsp_fault | output | 1 | Access faulted |
| mem_rd_req | output | 1 | Table read strobe |
| mem_rd_addr | output | 32 | Table read byte address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 32 | Table read data |
| flt_clr | input | 1 | Clear the fault record |
| flt_sticky | output | 1 | A fault has been recorded |
| flt_va | output | 32 | Recorded faulting virtual address |
| flt_kind | output | 2 | Recorded fault cause |

## Verification
The bench sweeps directory slots whose index ends in each of the four values of bits 1:0, and ten leaf slots in each table, with both read and write requests. A directory entry that carries both the present and exception bits must still fault; a design that only checked the present bit would hand out that leaf instead. Write-denied pages are hit again directly from the remembered translation. A register that skipped the permission check on a hit would return a real page where the safe page is due.

Base and enable changes followed by the same page catch a stale entry, which would show up as zero table reads. A second fault while the record is set checks that the first address survives. Secure and non-secure faults check that the two safe pages and their high bytes are not swapped.

// File: rtl/xw_pkg.sv
// Shared sizes and codes for the translation walker.
package xw_pkg;
    localparam int VA_W  = 32;
    localparam int PG_W  = 12;
    localparam int IDX_W = 10;
    localparam int VPN_W = VA_W - PG_W;
    localparam int HI_W  = 8;
    localparam int PA_W  = VA_W + HI_W;
    localparam int PPN_W = PA_W - PG_W;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_DIR   = 2'd1,
        FK_LEAF  = 2'd2,
        FK_WRITE = 2'd3
    } fault_kind_t;

    typedef enum logic [2:0] {
        S_IDLE, S_RD1, S_WT1, S_RD2, S_WT2, S_DONE
    } walk_state_t;
endpackage

// File: rtl/xw_entry_dec.sv
// Splits a 32-bit table word into its flag and address fields.
// Assumes bit 0 = present, bit 1 = exception, bit 2 = writable, bit 3 unused.
module xw_entry_dec
    import xw_pkg::*;
(
    input  logic [31:0]      ent,
    output logic             usable,
    output logic             writable,
    output logic [VPN_W-1:0] page,
    output logic [HI_W-1:0]  hi
);
    logic unused_rsvd;

    // Field extraction; an exception marker overrides the present bit.
    always_comb begin
        usable      = ent[0] & ~ent[1];
        writable    = ent[2];
        page        = ent[31:PG_W];
        hi          = ent[PG_W-1:4];
        unused_rsvd = ent[3];
    end
endmodule

// File: rtl/xw_last_xlate.sv
// One-entry memory of the last usable leaf: virtual page -> physical page.
// Assumes the owner gates fills with its own invalidate condition.
module xw_last_xlate
    import xw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inval,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_wr,
    input  logic             fill,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wr
);
    logic             vld_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic             wr_q;

    // Entry storage: flush wins over fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            vpn_q <= '0;
            ppn_q <= '0;
            wr_q  <= 1'b0;
        end else if (inval) begin
            vld_q <= 1'b0;
        end else if (fill) begin
            vld_q <= 1'b1;
            vpn_q <= fill_vpn;
            ppn_q <= fill_ppn;
            wr_q  <= fill_wr;
        end
    end

    // Lookup compare.
    always_comb begin
        lk_hit = vld_q && (vpn_q == lk_vpn);
        lk_ppn = ppn_q;
        lk_wr  = wr_q;
    end

    // R11: a flush leaves nothing to hit in the next cycle.
    a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> !lk_hit);
endmodule

// File: rtl/xw_fault_log.sv
// Sticky record of the first fault: virtual address and cause.
// Assumes ev is a single-cycle pulse; clear has priority over a new event.
module xw_fault_log
    import xw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev,
    input  logic [VA_W-1:0]  ev_va,
    input  fault_kind_t      ev_kind,
    input  logic             clr,
    output logic             sticky,
    output logic [VA_W-1:0]  va,
    output fault_kind_t      kind
);
    // Capture the first fault, hold until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= 1'b0;
            va     <= '0;
            kind   <= FK_NONE;
        end else if (clr) begin
            sticky <= 1'b0;
        end else if (ev && !sticky) begin
            sticky <= 1'b1;
            va     <= ev_va;
            kind   <= ev_kind;
        end
    end

    // R9: the record only sets following a fault event.
    a_r9_set_by_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky) |-> $past(ev));
    // R9: a set record keeps its address until cleared.
    a_r9_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !clr) |=> (sticky && $stable(va)));
endmodule

// File: rtl/xw_walker.sv
// Two-level translation walker, top level.
// Takes one request at a time, reads the directory and leaf words over a
// read port with no backpressure (one response per strobe, any later
// cycle), and answers with a translated or safe-page address.
// Assumes configuration inputs are held stable while a walk is in flight.
module xw_walker
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [VPN_W-1:0]  cfg_dir_page,
    input  logic [VPN_W-1:0]  cfg_safe_ns_page,
    input  logic [VPN_W-1:0]  cfg_safe_sec_page,
    input  logic [2*HI_W-1:0] cfg_safe_hi,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic              req_secure,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_fault,
    output logic              mem_rd_req,
    output logic [VA_W-1:0]   mem_rd_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              flt_clr,
    output logic              flt_sticky,
    output logic [VA_W-1:0]   flt_va,
    output logic [1:0]        flt_kind
);
    localparam int LEAF_IDX_LO = PG_W;
    localparam int DIR_IDX_LO  = PG_W + IDX_W;

    walk_state_t      st;
    logic [VA_W-1:0]  va_q;
    logic             wr_q, sec_q, on_q;
    logic [VPN_W-1:0] tbl_q;
    logic [PPN_W-1:0] ppn_q;
    fault_kind_t      kind_q;
    logic             en_seen_q;
    logic [VPN_W-1:0] dir_seen_q;

    logic             inval, accept, hit_raw, hit;
    logic [PPN_W-1:0] hit_ppn;
    logic             hit_wr;
    logic             e_usable, e_wr;
    logic [VPN_W-1:0] e_page;
    logic [HI_W-1:0]  e_hi;
    logic             fill;
    fault_kind_t      log_kind;

    xw_entry_dec i_dec (
        .ent      (mem_rdata),
        .usable   (e_usable),
        .writable (e_wr),
        .page     (e_page),
        .hi       (e_hi)
    );

    // Configuration change detect for flushing the remembered entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_seen_q  <= 1'b0;
            dir_seen_q <= '0;
        end else begin
            en_seen_q  <= cfg_enable;
            dir_seen_q <= cfg_dir_page;
        end
    end

    // Handshake, flush and fill conditions.
    always_comb begin
        inval  = (cfg_enable != en_seen_q) || (cfg_dir_page != dir_seen_q);
        accept = req_valid && req_ready;
        hit    = hit_raw && !inval;
        fill   = (st == S_WT2) && mem_rvalid && e_usable;
    end

    xw_last_xlate i_last (
        .clk      (clk),
        .rst_n    (rst_n),
        .inval    (inval),
        .lk_vpn   (req_va[VA_W-1:PG_W]),
        .lk_hit   (hit_raw),
        .lk_ppn   (hit_ppn),
        .lk_wr    (hit_wr),
        .fill     (fill),
        .fill_vpn (va_q[VA_W-1:PG_W]),
        .fill_ppn ({e_hi, e_page}),
        .fill_wr  (e_wr)
    );

    // Walk sequencer: accept, read directory, read leaf, answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            va_q   <= '0;
            wr_q   <= 1'b0;
            sec_q  <= 1'b0;
            on_q   <= 1'b0;
            tbl_q  <= '0;
            ppn_q  <= '0;
            kind_q <= FK_NONE;
        end else begin
            case (st)
                S_IDLE: if (accept) begin
                    va_q  <= req_va;
                    wr_q  <= req_write;
                    sec_q <= req_secure;
                    on_q  <= cfg_enable;
                    if (!cfg_enable) begin
                        ppn_q  <= {{HI_W{1'b0}}, req_va[VA_W-1:PG_W]};
                        kind_q <= FK_NONE;
                        st     <= S_DONE;
                    end else if (hit) begin
                        ppn_q  <= hit_ppn;
                        kind_q <= (req_write && !hit_wr) ? FK_WRITE : FK_NONE;
                        st     <= S_DONE;
                    end else begin
                        st <= S_RD1;
                    end
                end
                S_RD1: st <= S_WT1;
                S_WT1: if (mem_rvalid) begin
                    if (!e_usable) begin
                        kind_q <= FK_DIR;
                        st     <= S_DONE;
                    end else begin
                        tbl_q <= e_page;
                        st    <= S_RD2;
                    end
                end
                S_RD2: st <= S_WT2;
                S_WT2: if (mem_rvalid) begin
                    ppn_q <= {e_hi, e_page};
                    if (!e_usable)          kind_q <= FK_LEAF;
                    else if (wr_q && !e_wr) kind_q <= FK_WRITE;
                    else                    kind_q <= FK_NONE;
                    st <= S_DONE;
                end
                S_DONE:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Port drive: read strobe/address and result selection.
    always_comb begin
        req_ready   = (st == S_IDLE);
        mem_rd_req  = (st == S_RD1) || (st == S_RD2);
        mem_rd_addr = (st == S_RD2)
                    ? {tbl_q, va_q[DIR_IDX_LO-1:LEAF_IDX_LO], 2'b00}
                    : {cfg_dir_page, va_q[VA_W-1:DIR_IDX_LO], 2'b00};
        rsp_valid   = (st == S_DONE);
        rsp_fault   = (kind_q != FK_NONE);
        if (!rsp_fault)
            rsp_pa = {ppn_q, va_q[PG_W-1:0]};
        else if (sec_q)
            rsp_pa = {cfg_safe_hi[2*HI_W-1:HI_W], cfg_safe_sec_page, va_q[PG_W-1:0]};
        else
            rsp_pa = {cfg_safe_hi[HI_W-1:0], cfg_safe_ns_page, va_q[PG_W-1:0]};
    end

    xw_fault_log i_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (rsp_valid && rsp_fault),
        .ev_va   (va_q),
        .ev_kind (kind_q),
        .clr     (flt_clr),
        .sticky  (flt_sticky),
        .va      (flt_va),
        .kind    (log_kind)
    );
    assign flt_kind = log_kind;

    // R1: no table read while a new request could be taken.
    a_r1_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready);
    // R1: the result is a single-cycle pulse.
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R2: a request taken with translation off never reads the tables.
    a_r2_off_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_q && !req_ready) |-> !mem_rd_req);
    // R5: an unusable directory word ends the walk with no leaf read.
    a_r5_dir_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_WT1) && mem_rvalid && (!mem_rdata[0] || mem_rdata[1]))
        |=> (rsp_valid && rsp_fault));
endmodule

// File: tb/test_xw_walker.sv
module test_xw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [19:0] cfg_dir_page = 20'h00040;
    logic [19:0] cfg_safe_ns_page = 20'hCAFE1;
    logic [19:0] cfg_safe_sec_page = 20'h77703;
    logic [15:0] cfg_safe_hi = 16'hA55A;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic        rsp_valid;
    logic [39:0] rsp_pa;
    logic        rsp_fault;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        flt_clr = 1'b0;
    logic        flt_sticky;
    logic [31:0] flt_va;
    logic [1:0]  flt_kind;

    int n_chk = 0;
    int n_bad = 0;
    int rd_n = 0;
    logic [31:0] rd_a [0:3];

    // bench model of the remembered translation and the fault record
    logic        m_v = 1'b0;
    logic [19:0] m_vpn;
    logic [27:0] m_ppn;
    logic        m_w;
    logic        l_v = 1'b0;
    logic [31:0] l_va;
    logic [1:0]  l_kind;

    localparam logic [31:0] L2_REGION = 32'h0100_0000;

    always #4 clk = ~clk;

    xw_walker i_xw_walker (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input logic [31:0] a);
        int k, j;
        logic [31:0] pg;
        if (a[31:12] == 20'h00040 || a[31:12] == 20'h00080) begin
            k = int'(a[11:2]);
            if (k % 4 == 3) return 32'h3;
            if (k % 4 == 2) return 32'h0;
            return (L2_REGION + (k << 12)) | 32'h1;
        end
        if (a >= L2_REGION && a < L2_REGION + 32'h0040_0000) begin
            k = int'((a - L2_REGION) >> 12);
            j = int'(a[11:2]);
            if (j % 5 == 4) return 32'h3;
            if (j % 5 == 3) return 32'h0;
            pg = (32'h80000 + k * 256 + j) & 32'hFFFFF;
            return (pg << 12) | (((k * 7 + j) & 32'hFF) << 4) | ((j % 2 == 0) ? 32'h4 : 32'h0) | 32'h1;
        end
        return 32'h2;
    endfunction

    // table memory: answers one cycle after the strobe is seen
    initial begin
        logic pend;
        logic [31:0] pa;
        pend = 1'b0;
        pa = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend) begin
                mem_rvalid = 1'b1;
                mem_rdata = word_at(pa);
                pend = 1'b0;
            end
            if (mem_rd_req) begin
                pend = 1'b1;
                pa = mem_rd_addr;
                if (rd_n < 4) rd_a[rd_n] = mem_rd_addr;
                rd_n++;
            end
        end
    end

    task automatic xlate(input logic [31:0] va, input bit wr, input bit sec);
        logic [39:0] e_pa;
        logic        e_f;
        int          e_rd, k, j, cyc;
        logic [1:0]  kind;
        logic [31:0] ent, a1, a2;
        string       tag;
        k = int'(va[31:22]);
        j = int'(va[21:12]);
        kind = 2'd0;
        a1 = {cfg_dir_page, va[31:22], 2'b00};
        a2 = L2_REGION + (k << 12) + (j << 2);
        tag = "R6";
        if (!cfg_enable) begin
            e_rd = 0; e_pa = {8'h00, va}; tag = "R2";
        end else if (m_v && m_vpn == va[31:12]) begin
            e_rd = 0; e_pa = {m_ppn, va[11:0]}; tag = "R10";
            if (wr && !m_w) kind = 2'd3;
        end else if (k % 4 >= 2) begin
            e_rd = 1; kind = 2'd1; e_pa = '0;
        end else if (j % 5 >= 3) begin
            e_rd = 2; kind = 2'd2; e_pa = '0;
        end else begin
            e_rd = 2;
            ent = word_at(a2);
            e_pa = {ent[11:4], ent[31:12], va[11:0]};
            m_v = 1'b1; m_vpn = va[31:12]; m_ppn = {ent[11:4], ent[31:12]}; m_w = ent[2];
            if (wr && !ent[2]) kind = 2'd3;
        end
        e_f = (kind != 2'd0);
        if (e_f) begin
            e_pa = sec ? {cfg_safe_hi[15:8], cfg_safe_sec_page, va[11:0]}
                       : {cfg_safe_hi[7:0], cfg_safe_ns_page, va[11:0]};
            if (!l_v) begin l_v = 1'b1; l_va = va; l_kind = kind; end
        end
        @(negedge clk);
        rd_n = 0;
        req_valid = 1'b1; req_va = va; req_write = wr; req_secure = sec;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!rsp_valid && cyc < 40) begin @(negedge clk); cyc++; end
        chk(rsp_valid, "R1 response pulse", 64'(rsp_valid), 64'd1);
        chk(rsp_fault == e_f, (kind == 2'd3) ? "R7 write fault" : "R5 fault flag", 64'(rsp_fault), 64'(e_f));
        chk(rsp_pa == e_pa, e_f ? "R8 safe address" : tag, 64'(rsp_pa), 64'(e_pa));
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R1 single pulse", 64'(rsp_valid), 64'd0);
        chk(rd_n == e_rd, (e_rd == 0) ? "R10 no reads" : "R5 read count", 64'(rd_n), 64'(e_rd));
        if (e_rd >= 1) chk(rd_a[0] == a1, "R3 directory address", 64'(rd_a[0]), 64'(a1));
        if (e_rd == 2) chk(rd_a[1] == a2, "R4 leaf address", 64'(rd_a[1]), 64'(a2));
        chk(flt_sticky == l_v, "R9 sticky", 64'(flt_sticky), 64'(l_v));
        if (l_v) begin
            chk(flt_va == l_va, "R9 address", 64'(flt_va), 64'(l_va));
            chk(flt_kind == l_kind, "R9 kind", 64'(flt_kind), 64'(l_kind));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(req_ready && !rsp_valid && !mem_rd_req && !flt_sticky, "R12 reset outputs",
            {60'd0, req_ready, rsp_valid, mem_rd_req, flt_sticky}, 64'h8);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 pass-through while off
        xlate(32'h0000_0000, 1'b0, 1'b0);
        xlate(32'hFFFF_FFFF, 1'b1, 1'b1);
        xlate(32'h1234_5678, 1'b1, 1'b0);
        cfg_enable = 1'b1; m_v = 1'b0;
        @(negedge clk);
        // sweep directory slots of every class, leaf slots 0..9, read then write
        for (int t = 0; t < 8; t++) begin
            for (int j = 0; j < 10; j++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [9:0]  kd;
                    logic [11:0] off;
                    kd = 10'((t * 129) % 1024);
                    off = 12'((t * 341 + j * 3) & 12'hFFF);
                    xlate({kd, 10'(j), off}, w[0], ((j + w) % 2) == 1);
                end
            end
        end
        // R9 clear then re-record
        @(negedge clk); flt_clr = 1'b1;
        @(negedge clk); flt_clr = 1'b0; l_v = 1'b0;
        chk(!flt_sticky, "R9 cleared", 64'(flt_sticky), 64'd0);
        xlate({10'd3, 10'd0, 12'h0AB}, 1'b0, 1'b1);
        // R11 base change and enable toggle drop the remembered entry
        xlate({10'd1, 10'd0, 12'h010}, 1'b0, 1'b0);
        xlate({10'd1, 10'd0, 12'h020}, 1'b0, 1'b0);
        cfg_dir_page = 20'h00080; m_v = 1'b0;
        xlate({10'd1, 10'd0, 12'h030}, 1'b0, 1'b0); // R11 base
        cfg_enable = 1'b0;
        @(negedge clk);
        cfg_enable = 1'b1; m_v = 1'b0;
        xlate({10'd1, 10'd0, 12'h040}, 1'b1, 1'b0); // R11 enable
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule